// File: doc/BRIEF.md
# DX Multiple Recursive Generator with Chaos Mixing

This block is a linear auxiliary generator that produces one 31-bit word per step from an eight-word history. Each new word is the newest history word plus the oldest history word times (2^28 + 2^8), reduced modulo the Mersenne prime 2^31−1. The constant multiply costs no multiplier. Multiplying by a power of two modulo 2^31−1 is the same as rotating the word left, so the two partial products are two fixed rotations of the oldest word. The three operands then pass through a carry-save stage whose carry wraps from the top bit into bit 0. A single end-around-carry adder finishes the sum.

The block also forms a 32-bit mixed word from a 32-bit chaotic state that is supplied from outside. The top bit of that word passes straight through, and the low 31 bits are XORed with the current generator word. Software or a controlling block seeds the history with a load strobe and then advances it with a step enable, one word per enabled cycle.

Top module: `dx_mrg_gen`

## Requirements
- R1: While reset is asserted, and until the first load or step after it, `y_valid` is 0. The history holds its default, in which word i (0 = newest) has the value i+1, so `y_out` reads 1.
- R2: A load with a nonzero seed copies the eight words into the history on the next clock edge. Seed bits [31i+30:31i] are word i, word 0 is the newest and word 7 is the oldest. `y_out` then shows seed word 0 and `y_valid` is 0.
- R3: A load whose seed is all zero is rejected. The history returns to the reset default (word i = i+1) and `y_valid` is 0.
- R4: A step without load writes (Y0 + (2^28+2^8)·Y7) mod (2^31−1) as the newest word, where Y0 is the newest and Y7 the oldest word before the step. The new word appears on `y_out` one cycle later, with `y_valid` at 1.
- R5: On each step the history shifts by one word: each word moves one place older, and the oldest word is dropped.
- R6: A word produced by a step is never 2^31−1. A sum congruent to zero is output as 0.
- R7: With neither load nor step, the history and `y_out` hold their values.
- R8: When load and step are both high, the load wins and no step is taken.
- R9: `mix_out` bit 31 equals `chaos_in` bit 31, and `mix_out[30:0]` equals `chaos_in[30:0]` XOR `y_out`. The path is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Seed load strobe |
| seed | input | 248 | Eight 31-bit seed words, word 0 newest |
| step | input | 1 | Advance the generator by one word |
| chaos_in | input | 32 | External chaotic state to be mixed |
| y_out | output | 31 | Newest generator word |
| y_valid | output | 1 | Set by a step, cleared by reset or load |
| mix_out | output | 32 | Chaotic state mixed with the generator word |

## Verification
The recurrence runs for long stretches from the reset default and from several seeds. These include single-bit words, alternating patterns, mixed pseudo-random words and words of all ones (2^31−1, which is congruent to zero). Together they separate rotation-amount errors, carry-wrap errors in the carry-save stage and end-around-carry errors. Two seeds are built so that the first sum is exactly 2^31−1, both through the newest word alone and through a nonzero oldest word; these catch a missing wrap to zero. An all-zero seed, idle cycles, and load raised together with step each check the control priority. A changing chaotic input checks the mixed output on every cycle.

// File: rtl/dx_mrg_gen.sv
module dx_mrg_gen #(
  parameter int W     = 31,
  parameter int K     = 8,
  parameter int ROT_A = 28,
  parameter int ROT_B = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [K*W-1:0] seed,
  input  logic           step,
  input  logic [W:0]     chaos_in,
  output logic [W-1:0]   y_out,
  output logic           y_valid,
  output logic [W:0]     mix_out
);
  localparam logic [W-1:0] ONES = '1;

  logic [W-1:0] hist [K];
  logic [W-1:0] oldest, rot_a, rot_b;
  logic [W-1:0] csa_s, csa_c, csa_cw;
  logic [W:0]   eac_t;
  logic [W-1:0] eac_r, nxt;
  logic         seed_zero;

  assign seed_zero = (seed == '0);
  assign oldest    = hist[K-1];

  // multiply by 2^k mod (2^W-1) is a left rotation by k
  assign rot_a = (oldest << ROT_A) | (oldest >> (W - ROT_A));
  assign rot_b = (oldest << ROT_B) | (oldest >> (W - ROT_B));

  // circular 3:2 compression, top carry wraps into bit 0
  assign csa_s  = hist[0] ^ rot_a ^ rot_b;
  assign csa_c  = (hist[0] & rot_a) | (hist[0] & rot_b) | (rot_a & rot_b);
  assign csa_cw = {csa_c[W-2:0], csa_c[W-1]};

  // end-around-carry addition, then fold all-ones to zero
  assign eac_t = {1'b0, csa_s} + {1'b0, csa_cw};
  assign eac_r = eac_t[W-1:0] + {{(W-1){1'b0}}, eac_t[W]};
  assign nxt   = (eac_r == ONES) ? '0 : eac_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < K; i++) hist[i] <= W'(i + 1);
      y_valid <= 1'b0;
    end else if (load) begin
      for (int i = 0; i < K; i++)
        hist[i] <= seed_zero ? W'(i + 1) : seed[i*W +: W];
      y_valid <= 1'b0;
    end else if (step) begin
      hist[0] <= nxt;
      for (int i = 1; i < K; i++) hist[i] <= hist[i-1];
      y_valid <= 1'b1;
    end
  end

  assign y_out   = hist[0];
  assign mix_out = {chaos_in[W], chaos_in[W-1:0] ^ y_out};

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !seed_zero) |=> (y_out == $past(seed[W-1:0]) && !y_valid));

  p_zero_seed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && seed_zero) |=> (y_out == W'(1) && !y_valid));

  p_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> y_valid);

  p_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (hist[1] == $past(hist[0]) && hist[K-1] == $past(hist[K-2])));

  p_no_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (y_out != ONES));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> ($stable(y_out) && $stable(hist[K-1]) && $stable(y_valid)));
endmodule

// File: tb/dx_mrg_gen_bench.sv
module dx_mrg_gen_bench;
  localparam int W = 31;
  localparam int K = 8;
  localparam longint unsigned P = (64'd1 << 31) - 1;
  localparam longint unsigned MULC = (64'd1 << 28) + (64'd1 << 8);

  logic clk = 0;
  logic rst_n = 0;
  logic load = 0;
  logic [K*W-1:0] seed = '0;
  logic step = 0;
  logic [W:0] chaos_in = '0;
  logic [W-1:0] y_out;
  logic y_valid;
  logic [W:0] mix_out;

  dx_mrg_gen u_dx_mrg_gen (
    .clk(clk), .rst_n(rst_n), .load(load), .seed(seed), .step(step),
    .chaos_in(chaos_in), .y_out(y_out), .y_valid(y_valid), .mix_out(mix_out)
  );

  always #5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic [W-1:0] m [K];
  logic exp_v;
  logic [31:0] cx = 32'h1234_5678;

  task automatic chk(input bit ok, input string tag, input longint unsigned act,
                     input longint unsigned expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [W-1:0] model_next(input logic [W-1:0] a, input logic [W-1:0] b);
    longint unsigned v;
    v = (longint'(a) + longint'(b) * MULC) % P;
    return W'(v);
  endfunction

  task automatic model_default();
    for (int i = 0; i < K; i++) m[i] = W'(i + 1);
    exp_v = 0;
  endtask

  task automatic cyc(input bit ld, input logic [K*W-1:0] sd, input bit st, input string tag);
    logic [W-1:0] nv;
    @(negedge clk);
    cx = cx ^ (cx << 13); cx = cx ^ (cx >> 17); cx = cx ^ (cx << 5);
    chaos_in = cx;
    load = ld; seed = sd; step = st;
    @(posedge clk);
    #1;
    if (ld) begin
      if (sd == '0) model_default();
      else begin
        for (int i = 0; i < K; i++) m[i] = sd[i*W +: W];
        exp_v = 0;
      end
    end else if (st) begin
      nv = model_next(m[0], m[K-1]);
      for (int i = K-1; i > 0; i--) m[i] = m[i-1];
      m[0] = nv;
      exp_v = 1;
    end
    chk(y_out == m[0], tag, y_out, m[0]);
    chk(y_valid == exp_v, {tag, " valid"}, y_valid, exp_v);
    chk(mix_out == {chaos_in[W], chaos_in[W-1:0] ^ m[0]}, "R9 mix", mix_out,
        {chaos_in[W], chaos_in[W-1:0] ^ m[0]});
  endtask

  task automatic run_steps(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, '0, 1, tag);
  endtask

  function automatic logic [K*W-1:0] mk_seed(input logic [W-1:0] w [K]);
    logic [K*W-1:0] s;
    for (int i = 0; i < K; i++) s[i*W +: W] = w[i];
    return s;
  endfunction

  initial begin
    logic [W-1:0] w [K];
    logic [W-1:0] held;
    logic [31:0] r;
    model_default();
    repeat (3) @(posedge clk);
    #1;
    chk(y_out == 31'd1, "R1 reset y_out", y_out, 1);
    chk(y_valid == 0, "R1 reset valid", y_valid, 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    chk(y_out == 31'd1 && y_valid == 0, "R1 after reset", y_out, 1);

    run_steps(1500, "R4 R5 default seq");

    // single-bit words
    for (int i = 0; i < K; i++) w[i] = W'(1) << (i * 4);
    cyc(1, mk_seed(w), 0, "R2 load bits");
    run_steps(1200, "R4 bits seq");

    // alternating and all-ones words
    for (int i = 0; i < K; i++) w[i] = (i % 2 == 0) ? 31'h2AAA_AAAA : 31'h7FFF_FFFF;
    cyc(1, mk_seed(w), 0, "R2 load alt");
    run_steps(1200, "R4 alt seq");

    // pseudo-random words
    r = 32'hCAFE_F00D;
    for (int i = 0; i < K; i++) begin
      r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
      w[i] = r[30:0];
    end
    cyc(1, mk_seed(w), 0, "R2 load rand");
    run_steps(1500, "R4 R5 rand seq");

    // R7: idle cycles hold
    held = y_out;
    for (int i = 0; i < 5; i++) begin
      cyc(0, '0, 0, "R7 idle");
      chk(y_out == held, "R7 hold", y_out, held);
    end

    // R8: load with step, load wins
    for (int i = 0; i < K; i++) w[i] = W'(100 + i);
    cyc(1, mk_seed(w), 1, "R8 load over step");
    chk(y_out == 31'd100 && y_valid == 0, "R8 no step", y_out, 100);

    // R3: zero seed restores default
    cyc(1, '0, 0, "R3 zero seed");
    chk(y_out == 31'd1, "R3 default word", y_out, 1);
    run_steps(300, "R3 default seq");

    // R6: sum equal to modulus via newest word alone
    for (int i = 0; i < K; i++) w[i] = W'(5 + i);
    w[0] = 31'h7FFF_FFFF; w[K-1] = '0;
    cyc(1, mk_seed(w), 0, "R2 load edge a");
    cyc(0, '0, 1, "R6 edge a");
    chk(y_out == '0, "R6 wrap zero a", y_out, 0);

    // R6: sum equal to modulus with nonzero oldest word
    w[K-1] = 31'd1;
    w[0] = W'(P - MULC);
    cyc(1, mk_seed(w), 0, "R2 load edge b");
    cyc(0, '0, 1, "R6 edge b");
    chk(y_out == '0, "R6 wrap zero b", y_out, 0);
    run_steps(200, "R4 after edge");

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule